// File: doc/BRIEF.md
# Sensor Sample Byte FIFO

The block gathers a frame of up to seven 16-bit sensor words each time a sample strobe arrives and stores it, one byte per clock cycle, in a byte-wide ring buffer. Five per-source flags choose which words make up the frame. One flag covers the three accelerometer axes as a group. The other four cover the temperature word and each gyro axis.

Software-side logic reads the buffer one byte at a time through a small register port with three selections: data, count high byte, and count low byte. A mode input decides what happens when a byte arrives at a full buffer. In one mode the new byte is dropped. In the other mode the oldest byte is overwritten. Either way, a one-cycle overflow pulse is raised. An empty or disabled data read returns 0xFF, and no stored byte is ever 0xFF. A one-cycle clear request empties the buffer.

Top module: `sample_fifo`

## Requirements
- R1: Frame order and flags. The words are indexed 0 to 6 as accel X, accel Y, accel Z, temperature, gyro X, gyro Y, gyro Z. Each enabled word is stored high byte first, and words are stored in ascending index order. The flag bits of `src_en_i` are: bit 0 for words 0 to 2 together, bit 1 for temperature, and bits 2 to 4 for gyro X, Y and Z. Words whose flag is clear are skipped.
- R2: The strobe is captured on the edge where `sample_i` is high, and the frame's bytes are written on the following edges, one per cycle. A strobe that arrives while a frame is still being written is ignored.
- R3: A data byte of 0xFF is stored as 0xFE. Every other byte value is stored unchanged.
- R4: When `drop_new_i` is 1 and the buffer is full, an arriving byte is discarded and the stored contents and count are unchanged.
- R5: When `drop_new_i` is 0 and the buffer is full, an arriving byte replaces the oldest byte and the count stays at DEPTH.
- R6: Every byte that arrives at a full buffer, with no pop on the same edge, produces exactly one cycle of `ovf_o` high.
- R7: A data read (`rd_sel_i` = 0) from an empty buffer returns 0xFF and leaves the count unchanged.
- R8: A count-high read (`rd_sel_i` = 1) returns {3'b0, count[12:8]} and latches count[7:0]. A count-low read (`rd_sel_i` = 2) returns that latched byte, even if the count has changed since the high read.
- R9: A one-cycle `clear_i` pulse sets an internal request bit that clears itself after one cycle. That request empties the buffer and aborts any frame in progress, so the count reads 0 afterwards.
- R10: While `enable_i` is low, strobes are ignored, no bytes are written, and data reads return 0xFF without removing a byte.
- R11: The count never exceeds DEPTH (512 by default) and holds at DEPTH while the buffer is full.
- R12: After reset the buffer is empty, the count reads 0, and `ovf_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Global enable for writes and data reads |
| sample_i | input | 1 | Sample strobe, one cycle |
| src_en_i | input | 5 | Per-source enable flags (see R1) |
| words_i | input | 112 | Seven 16-bit words; word n at bits [16n+15:16n] |
| drop_new_i | input | 1 | 1: drop bytes when full; 0: overwrite oldest |
| clear_i | input | 1 | Buffer clear request |
| rd_i | input | 1 | Read pulse |
| rd_sel_i | input | 2 | 0 data, 1 count high, 2 count low, 3 reads 0 |
| rd_data_o | output | 8 | Read result, valid from the cycle after the read |
| ovf_o | output | 1 | Overflow pulse |

## Verification
Frame bytes land on the edges 1 to 14 after the strobe edge. The bench therefore waits 16 cycles after each strobe before it reads anything back. A read result is registered on the read edge, so the bench samples it at the next falling edge.

A clear needs two edges to take effect: one to register the request and one to empty the buffer. Counts are read only after both edges. Overflow pulses are counted at falling edges and compared against the reference model's count of bytes that arrived at a full buffer.

// File: rtl/sample_fifo_pkg.sv
package sample_fifo_pkg;
  localparam int unsigned NUM_WORDS   = 7;
  localparam int unsigned NUM_FLAGS   = 5;
  localparam int unsigned FRAME_BYTES = 2 * NUM_WORDS;
  localparam logic [7:0]  EMPTY_CODE  = 8'hFF;
  localparam logic [7:0]  SUBST_CODE  = 8'hFE;

  localparam logic [1:0] SEL_DATA   = 2'd0;
  localparam logic [1:0] SEL_CNT_HI = 2'd1;
  localparam logic [1:0] SEL_CNT_LO = 2'd2;

  // byte index -> flag bit: accel bytes share flag 0, then one flag per word
  function automatic int unsigned flag_of_byte(int unsigned b);
    if (b < 6) return 0;
    return b / 2 - 2;
  endfunction
endpackage

// File: rtl/frame_serializer.sv
module frame_serializer
  import sample_fifo_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               clr_i,
  input  logic                               en_i,
  input  logic                               strobe_i,
  input  logic [NUM_FLAGS-1:0]               src_en_i,
  input  logic [NUM_WORDS-1:0][15:0]         words_i,
  output logic                               push_o,
  output logic [7:0]                         byte_o
);
  logic [FRAME_BYTES-1:0]      mask_q, load_mask, pick;
  logic [FRAME_BYTES-1:0][7:0] bytes_q, load_bytes;

  for (genvar b = 0; b < FRAME_BYTES; b++) begin : g_byte
    localparam int unsigned WI = b / 2;
    localparam bit          LO = (b % 2) == 1;
    logic [7:0] raw;
    assign raw           = LO ? words_i[WI][7:0] : words_i[WI][15:8];
    assign load_bytes[b] = (raw == EMPTY_CODE) ? SUBST_CODE : raw;
    assign load_mask[b]  = src_en_i[flag_of_byte(b)];
  end

  assign pick = mask_q & (~mask_q + 1'b1);

  always_comb begin
    byte_o = '0;
    for (int b = 0; b < FRAME_BYTES; b++)
      if (pick[b]) byte_o = byte_o | bytes_q[b];
  end

  assign push_o = (|mask_q) && en_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      bytes_q <= '0;
    end else if (clr_i) begin
      mask_q <= '0;
    end else if (mask_q == '0) begin
      if (strobe_i && en_i) begin
        mask_q  <= load_mask;
        bytes_q <= load_bytes;
      end
    end else begin
      mask_q <= mask_q & ~pick;
    end
  end

  // R3
  sub_never_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> byte_o != EMPTY_CODE);
endmodule

// File: rtl/byte_ring.sv
module byte_ring #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [7:0]       push_byte_i,
  input  logic             pop_i,
  input  logic             drop_new_i,
  output logic [7:0]       head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             empty, full, do_pop, room, do_push, overwrite;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = cnt_q == '0;
  assign full      = cnt_q == FULL_CNT;
  assign do_pop    = pop_i && !empty;
  assign room      = !full || do_pop;
  assign do_push   = push_i && room;
  assign overwrite = push_i && !room && !drop_new_i;

  always_ff @(posedge clk_i) begin
    if (!clr_i && (do_push || overwrite)) mem[wr_ptr_q] <= push_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (do_push || overwrite) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop || overwrite)  rd_ptr_q <= nxt(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
      ovf_q <= push_i && !room;
    end
  end

  assign head_o  = mem[rd_ptr_q];
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  // R11
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);
  // R4
  drop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && drop_new_i && !clr_i)
      |=> $stable(count_o) && $stable(wr_ptr_q) && $stable(rd_ptr_q));
  // R5
  overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !drop_new_i && !clr_i)
      |=> count_o == FULL_CNT && !$stable(rd_ptr_q));
  // R6
  ovf_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(full));
  // R9
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
  import sample_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned CNT_W = 13
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       enable_i,
  input  logic                       sample_i,
  input  logic [4:0]                 src_en_i,
  input  logic [6:0][15:0]           words_i,
  input  logic                       drop_new_i,
  input  logic                       clear_i,
  input  logic                       rd_i,
  input  logic [1:0]                 rd_sel_i,
  output logic [7:0]                 rd_data_o,
  output logic                       ovf_o
);
  logic             clr_q, push, pop;
  logic [7:0]       push_byte, head, rd_data_q, snap_lo_q;
  logic [CNT_W-1:0] count;

  // self-clearing clear request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= clear_i;
  end

  frame_serializer u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_q),
    .en_i     (enable_i),
    .strobe_i (sample_i),
    .src_en_i (src_en_i),
    .words_i  (words_i),
    .push_o   (push),
    .byte_o   (push_byte)
  );

  assign pop = rd_i && (rd_sel_i == SEL_DATA) && enable_i && !clr_q;

  byte_ring #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_q),
    .push_i      (push),
    .push_byte_i (push_byte),
    .pop_i       (pop),
    .drop_new_i  (drop_new_i),
    .head_o      (head),
    .count_o     (count),
    .ovf_o       (ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q <= '0;
      snap_lo_q <= '0;
    end else if (rd_i) begin
      case (rd_sel_i)
        SEL_DATA:   rd_data_q <= (pop && count != '0) ? head : EMPTY_CODE;
        SEL_CNT_HI: begin
          rd_data_q <= 8'(count >> 8);
          snap_lo_q <= count[7:0];
        end
        SEL_CNT_LO: rd_data_q <= snap_lo_q;
        default:    rd_data_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_data_q;

  // R7
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_sel_i == SEL_DATA && count == '0 && !clr_q)
      |=> rd_data_o == EMPTY_CODE && count == '0);
  // R10
  disabled_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_sel_i == SEL_DATA && !enable_i && !clr_q)
      |=> rd_data_o == EMPTY_CODE && $stable(count));
endmodule

// File: tb/sample_fifo_test.sv
`timescale 1ns/1ps
module sample_fifo_test;
  localparam int DEPTH = 512;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            enable = 1'b1, sample = 1'b0, drop_new = 1'b1, clear = 1'b0;
  logic            rd = 1'b0;
  logic [1:0]      rd_sel = 2'd0;
  logic [4:0]      src_en = 5'd0;
  logic [6:0][15:0] words = '0;
  logic [7:0]      rd_data;
  logic            ovf;

  int checks = 0, failures = 0;
  int ovf_seen = 0, ovf_exp = 0;
  bit done = 1'b0;
  logic [7:0] q[$];

  always #2.5 clk = ~clk;

  sample_fifo #(.DEPTH(DEPTH), .CNT_W(13)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .sample_i(sample),
    .src_en_i(src_en), .words_i(words), .drop_new_i(drop_new), .clear_i(clear),
    .rd_i(rd), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .ovf_o(ovf)
  );

  always @(negedge clk) if (rst_n && ovf) ovf_seen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int flag_bit(int b);
    if (b < 6) return 0;
    if (b < 8) return 1;
    return (b - 8) / 2 + 2;
  endfunction

  task automatic model_push(logic [7:0] v);
    if (q.size() == DEPTH) begin
      ovf_exp++;
      if (!drop_new) begin
        void'(q.pop_front());
        q.push_back(v);
      end
    end else q.push_back(v);
  endtask

  task automatic frame(logic [4:0] en, logic [6:0][15:0] w);
    @(negedge clk);
    src_en = en; words = w; sample = 1'b1;
    @(negedge clk);
    sample = 1'b0;
    if (enable)
      for (int b = 0; b < 14; b++) begin
        logic [7:0] v;
        if (!en[flag_bit(b)]) continue;
        v = (b % 2) ? w[b/2][7:0] : w[b/2][15:8];
        if (v == 8'hFF) v = 8'hFE;
        model_push(v);
      end
    repeat (16) @(negedge clk);
  endtask

  task automatic do_read(logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    rd = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd = 1'b0;
    v = rd_data;
  endtask

  task automatic check_count(string req);
    logic [7:0] hi, lo;
    do_read(2'd1, hi);
    do_read(2'd2, lo);
    chk(req, {hi, lo}, q.size());
  endtask

  task automatic pop_check(int n, string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      do_read(2'd0, v);
      chk(req, v, (q.size() != 0) ? q.pop_front() : 8'hFF);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    @(negedge clk);
    q.delete();
  endtask

  function automatic logic [6:0][15:0] rand_words();
    logic [6:0][15:0] w;
    for (int i = 0; i < 7; i++) begin
      w[i] = 16'($urandom);
      if ($urandom_range(3) == 0) w[i][7:0] = 8'hFF;
      if ($urandom_range(3) == 0) w[i][15:8] = 8'hFF;
    end
    return w;
  endfunction

  initial begin
    logic [7:0] v, hi, lo;
    logic [6:0][15:0] w;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state, R7 empty read
    chk("R12 ovf", ovf, 0);
    check_count("R12 count");
    pop_check(1, "R7 empty read");
    check_count("R7 count unchanged");

    // R1 R3 directed full frame
    w = '{16'h1111, 16'hFFAB, 16'h12FF, 16'h0102, 16'hFFFF, 16'h7E80, 16'hA5C3};
    frame(5'b11111, w);
    check_count("R1 count");
    pop_check(14, "R1 R3 order");

    // R1 partial flags: temp and gyro Z
    frame(5'b10010, rand_words());
    check_count("R1 partial count");
    pop_check(4, "R1 partial order");

    // R2 strobe during frame ignored
    @(negedge clk);
    src_en = 5'b11111; words = rand_words(); sample = 1'b1;
    w = words;
    @(negedge clk); sample = 1'b0;
    @(negedge clk); words = rand_words(); sample = 1'b1;
    @(negedge clk); sample = 1'b0;
    for (int b = 0; b < 14; b++) begin
      v = (b % 2) ? w[b/2][7:0] : w[b/2][15:8];
      model_push((v == 8'hFF) ? 8'hFE : v);
    end
    repeat (16) @(negedge clk);
    check_count("R2 count");
    pop_check(14, "R2 data");

    // random mix
    for (int it = 0; it < 30; it++) begin
      drop_new = 1'($urandom);
      frame(5'($urandom), rand_words());
      if ($urandom_range(2) == 0) check_count("R1 random count");
      pop_check($urandom_range(10), "R1 R3 random data");
    end
    check_count("R1 random count");
    pop_check(q.size(), "R1 random drain");
    chk("R6 random ovf", ovf_seen, ovf_exp);

    // R4 R11 R6 drop mode fill
    drop_new = 1'b1;
    for (int i = 0; i < 38; i++) frame(5'b11111, rand_words());
    check_count("R11 full count");
    chk("R6 drop ovf", ovf_seen, ovf_exp);
    pop_check(20, "R4 oldest kept");

    // R9 clear
    do_clear();
    check_count("R9 cleared");
    pop_check(1, "R9 empty after clear");

    // R5 overwrite mode fill
    drop_new = 1'b0;
    for (int i = 0; i < 38; i++) frame(5'b11111, rand_words());
    check_count("R5 full count");
    chk("R6 overwrite ovf", ovf_seen, ovf_exp);
    pop_check(20, "R5 newest kept");
    do_clear();

    // R8 count snapshot
    frame(5'b11111, rand_words());
    do_read(2'd1, hi);
    chk("R8 hi", hi, 0);
    frame(5'b11111, rand_words());
    do_read(2'd2, lo);
    chk("R8 latched lo", lo, 14);
    check_count("R8 fresh count");

    // R10 enable low
    enable = 1'b0;
    frame(5'b11111, rand_words());
    do_read(2'd0, v);
    chk("R10 read while disabled", v, 8'hFF);
    check_count("R10 count unchanged");
    enable = 1'b1;
    pop_check(q.size(), "R10 data intact");
    chk("R6 final ovf", ovf_seen, ovf_exp);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule